// File: doc/BRIEF.md
# Interrupt, Reset and Return Sequencer

This block runs the bus sequences a small 8-bit processor core needs to enter and leave exception handlers. It covers four entry causes: power-on reset, a non-maskable interrupt line, a maskable interrupt line and a software break request from the instruction decoder. It also covers the return-from-handler request. For each sequence it issues exactly one access per clock on a simple bus made of a 16-bit address, write data, a write enable and combinational read data. It keeps an 8-bit stack pointer that always addresses page one of memory, and at the end it hands a new program counter and status byte back to the core.

The core keeps `pcIn` and `statusIn` steady while `busy` is high. A cause is accepted only while the sequencer is idle, with one exception: a hardware interrupt may take over a break sequence that is already running. When a sequence finishes, `done` pulses for one cycle and `pcOut`/`statusOut` hold the values the core should load. Opcode decoding and arithmetic belong to other blocks.

Top module: `irq_stack_seq`

## Requirements
- R1: After `rstN` is released the block is busy for 7 bus cycles and performs no write. In the last two of those cycles it reads 0xFFFC and then 0xFFFD. It then delivers `pcOut` = {byte read at 0xFFFD, byte read at 0xFFFC}, and `statusOut` is `statusIn` with bit 2 (interrupt mask) set, bit 5 set and bit 4 clear. Reset leaves the stack pointer at 0xFF.
- R2: A rising edge on `nmiReq` is latched and starts one sequence. Holding the line high starts no second one. The sequence is 7 bus cycles: two dummy reads at `pcIn`, then writes of `pcIn` high byte, `pcIn` low byte and the status copy, then reads of 0xFFFA and 0xFFFB.
- R3: `irqReq` is level-sensitive and is ignored while `statusIn` bit 2 is 1. When it is taken it follows the R2 sequence but reads its vector from 0xFFFE/0xFFFF.
- R4: A break request follows the R3 sequence. The pushed return address is `pcIn` + 2, and the pushed status copy has bit 4 set.
- R5: When several causes are present in an idle cycle, the non-maskable interrupt is chosen first, then the maskable interrupt, then break, then return. A break request that loses this choice is dropped.
- R6: A push writes to 0x0100 + pointer and then decrements the pointer. A pull increments the pointer first and then reads 0x0100 + pointer. The pointer wraps modulo 256.
- R7: If a hardware interrupt is pending during the first four cycles of a break sequence, the break is lost. The status copy is pushed with bit 4 clear, the vector comes from that interrupt, the return address stays `pcIn` + 2, and a latched NMI edge is consumed.
- R8: A return request takes 6 bus cycles: two dummy reads at `pcIn`, a dummy read at 0x0100 + pointer, and then three pulls giving status, PC low and PC high. `statusOut` is the pulled status with bit 4 cleared and bit 5 set.
- R9: There is a bus access in every cycle. Whenever no write occurs `busWe` is 0, and while idle the address is `pcIn`.
- R10: `done` is high for exactly one cycle, the cycle after `busy` falls. `pcOut` and `statusOut` change only as `done` rises. On entry, status bit 3 (decimal) passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; its release starts the reset sequence |
| nmiReq | input | 1 | Non-maskable interrupt line, edge-triggered |
| irqReq | input | 1 | Maskable interrupt line, level-sensitive |
| brkReq | input | 1 | Software break request from decode |
| rtiReq | input | 1 | Return-from-handler request from decode |
| pcIn | input | 16 | Current program counter |
| statusIn | input | 8 | Current status byte; bit 2 is the interrupt mask |
| busRdata | input | 8 | Read data for the current address |
| busAddr | output | 16 | Bus address, valid every cycle |
| busWdata | output | 8 | Bus write data |
| busWe | output | 1 | Write enable |
| pcOut | output | 16 | Program counter to load |
| statusOut | output | 8 | Status byte to load |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse: pcOut/statusOut are fresh |

## Verification
Most internal faults appear at the ports within one sequence. A stack pointer that is off by one, or that moves in the wrong direction, puts the very next push or pull at the wrong page-one address. A wrongly decoded cause or a missed takeover produces the wrong vector read two cycles before `done`, or a wrong bit 4 in the third write. A step counter that miscounts shows up as an extra or missing bus cycle against the expected transaction stream. A mishandled NMI latch shows up as a second sequence, or a missing one, a few cycles after the line changes.

// File: rtl/irq_stack_seq_pkg.sv
package irq_stack_seq_pkg;
  localparam int MASK_BIT = 2;
  localparam int DEC_BIT  = 3;
  localparam int BRK_BIT  = 4;
  localparam int ONE_BIT  = 5;

  typedef enum logic [2:0] {K_RST, K_NMI, K_IRQ, K_BRK, K_RTI} cause_e;
  typedef enum logic [2:0] {A_PC, A_STK, A_STKUP, A_VLO, A_VHI} addrSel_e;
  typedef enum logic [1:0] {W_PCH, W_PCL, W_STAT} wSel_e;

  typedef struct packed {
    cause_e   cause;
    addrSel_e addrSel;
    wSel_e    wSel;
    logic     we;
    logic     spDec;
    logic     spInc;
    logic     latchRet;
    logic     retPlus2;
    logic     capStat;
    logic     capLow;
    logic     finish;
  } strobe_t;
endpackage

// File: rtl/irq_stack_seq_ctrl.sv
module irq_stack_seq_ctrl
  import irq_stack_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    nmiReq,
  input  logic    irqReq,
  input  logic    brkReq,
  input  logic    rtiReq,
  input  logic    iMask,
  output strobe_t strb,
  output logic    busy
);
  localparam logic [STEP_W-1:0] ENTRY_LAST  = STEP_W'(6);
  localparam logic [STEP_W-1:0] RTI_LAST    = STEP_W'(5);
  localparam logic [STEP_W-1:0] HIJACK_LAST = STEP_W'(3);

  logic              run;
  cause_e            cause;
  logic [STEP_W-1:0] step;
  logic              nmiPrev, nmiPend;
  logic              nmiRise, nmiLive, irqLive;
  logic              startVld, hijack, nmiTake;
  cause_e            startCause, hijackCause;
  logic [STEP_W-1:0] lastStep;

  assign nmiRise  = nmiReq & ~nmiPrev;
  assign nmiLive  = nmiPend | nmiRise;
  assign irqLive  = irqReq & ~iMask;
  assign lastStep = (cause == K_RTI) ? RTI_LAST : ENTRY_LAST;
  assign hijack   = run && (cause == K_BRK) && (step <= HIJACK_LAST) && (nmiLive || irqLive);
  assign hijackCause = nmiLive ? K_NMI : K_IRQ;
  assign busy     = run;

  always_comb begin
    startVld   = 1'b1;
    startCause = K_RTI;
    if (nmiLive)      startCause = K_NMI;
    else if (irqLive) startCause = K_IRQ;
    else if (brkReq)  startCause = K_BRK;
    else if (rtiReq)  startCause = K_RTI;
    else              startVld   = 1'b0;
    if (run) startVld = 1'b0;
  end

  assign nmiTake = (startVld && startCause == K_NMI) || (hijack && nmiLive);

  always_comb begin
    strb = '0;
    strb.cause   = cause;
    strb.addrSel = A_PC;
    strb.wSel    = W_PCH;
    if (!run) begin
      strb.latchRet = startVld;
      strb.retPlus2 = startCause == K_BRK;
    end else if (cause == K_RTI) begin
      case (step)
        3'd2: strb.addrSel = A_STK;
        3'd3: begin strb.addrSel = A_STKUP; strb.spInc = 1'b1; strb.capStat = 1'b1; end
        3'd4: begin strb.addrSel = A_STKUP; strb.spInc = 1'b1; strb.capLow  = 1'b1; end
        3'd5: begin strb.addrSel = A_STKUP; strb.spInc = 1'b1; strb.finish  = 1'b1; end
        default: ;
      endcase
    end else begin
      case (step)
        3'd2, 3'd3, 3'd4: begin
          strb.addrSel = A_STK;
          strb.we      = cause != K_RST;
          strb.spDec   = cause != K_RST;
          strb.wSel    = (step == 3'd2) ? W_PCH : (step == 3'd3) ? W_PCL : W_STAT;
        end
        3'd5: begin strb.addrSel = A_VLO; strb.capLow = 1'b1; end
        3'd6: begin strb.addrSel = A_VHI; strb.finish = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run     <= 1'b1;
      cause   <= K_RST;
      step    <= '0;
      nmiPrev <= 1'b0;
      nmiPend <= 1'b0;
    end else begin
      nmiPrev <= nmiReq;
      nmiPend <= nmiLive & ~nmiTake;
      if (!run) begin
        if (startVld) begin
          run   <= 1'b1;
          cause <= startCause;
          step  <= '0;
        end
      end else begin
        if (step == lastStep) run <= 1'b0;
        else step <= step + STEP_W'(1);
        if (hijack) cause <= hijackCause;
      end
    end
  end

  // An idle cycle that sees a fresh NMI edge always commits to the NMI sequence
  assert_nmi_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(nmiReq) && !run) |=> (run && cause == K_NMI));

  // A return sequence never writes the bus
  assert_rti_read_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    (run && cause == K_RTI) |-> !strb.we);
endmodule

// File: rtl/irq_stack_seq_dp.sv
module irq_stack_seq_dp
  import irq_stack_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 'h01,
  parameter logic [ADDR_W-1:0] NMI_VEC = 'hFFFA,
  parameter logic [ADDR_W-1:0] RST_VEC = 'hFFFC,
  parameter logic [ADDR_W-1:0] IRQ_VEC = 'hFFFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              busWe,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] statusOut,
  output logic              done
);
  logic [DATA_W-1:0] sp, spUp, lowByte, pullStat, pushStat;
  logic [ADDR_W-1:0] retPc, vecBase;
  logic [DATA_W-1:0] entryStat, rtiStat;

  assign spUp = sp + DATA_W'(1);

  always_comb begin
    case (strb.cause)
      K_NMI:   vecBase = NMI_VEC;
      K_RST:   vecBase = RST_VEC;
      default: vecBase = IRQ_VEC;
    endcase
    case (strb.addrSel)
      A_STK:   busAddr = {STACK_PAGE, sp};
      A_STKUP: busAddr = {STACK_PAGE, spUp};
      A_VLO:   busAddr = vecBase;
      A_VHI:   busAddr = vecBase + ADDR_W'(1);
      default: busAddr = pcIn;
    endcase
    pushStat = statusIn;
    pushStat[ONE_BIT] = 1'b1;
    pushStat[BRK_BIT] = strb.cause == K_BRK;
    entryStat = statusIn;
    entryStat[ONE_BIT]  = 1'b1;
    entryStat[BRK_BIT]  = 1'b0;
    entryStat[MASK_BIT] = 1'b1;
    rtiStat = pullStat;
    rtiStat[ONE_BIT] = 1'b1;
    rtiStat[BRK_BIT] = 1'b0;
    case (strb.wSel)
      W_PCH:   busWdata = retPc[ADDR_W-1:DATA_W];
      W_PCL:   busWdata = retPc[DATA_W-1:0];
      default: busWdata = pushStat;
    endcase
  end

  assign busWe = strb.we;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp        <= '1;
      retPc     <= '0;
      lowByte   <= '0;
      pullStat  <= '0;
      pcOut     <= '0;
      statusOut <= '0;
      done      <= 1'b0;
    end else begin
      done <= strb.finish;
      if (strb.latchRet) retPc <= pcIn + {{(ADDR_W-2){1'b0}}, strb.retPlus2, 1'b0};
      if (strb.spDec)    sp <= sp - DATA_W'(1);
      if (strb.spInc)    sp <= spUp;
      if (strb.capLow)   lowByte <= busRdata;
      if (strb.capStat)  pullStat <= busRdata;
      if (strb.finish) begin
        pcOut     <= {busRdata, lowByte};
        statusOut <= (strb.cause == K_RTI) ? rtiStat : entryStat;
      end
    end
  end

  assert_push_in_page_R6: assert property (@(posedge clk) disable iff (!rstN)
    busWe |-> (busAddr[ADDR_W-1:DATA_W] == STACK_PAGE));

  assert_push_then_dec_R6: assert property (@(posedge clk) disable iff (!rstN)
    busWe |=> (sp == $past(sp) - DATA_W'(1)));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_pc_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pcOut) |-> done);
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irq_stack_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiReq,
  input  logic              irqReq,
  input  logic              brkReq,
  input  logic              rtiReq,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              busWe,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] statusOut,
  output logic              busy,
  output logic              done
);
  strobe_t strb;

  irq_stack_seq_ctrl #(.STEP_W(3)) u_ctrl (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .irqReq(irqReq),
    .brkReq(brkReq), .rtiReq(rtiReq), .iMask(statusIn[MASK_BIT]),
    .strb(strb), .busy(busy)
  );

  irq_stack_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pcIn(pcIn), .statusIn(statusIn),
    .busRdata(busRdata), .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
    .pcOut(pcOut), .statusOut(statusOut), .done(done)
  );

  assert_done_follows_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
endmodule

// File: tb/irq_stack_seq_bench.sv
module irq_stack_seq_bench;
  import irq_stack_seq_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nmiReq = 1'b0, irqReq = 1'b0, brkReq = 1'b0, rtiReq = 1'b0;
  logic [15:0] pcIn = 16'h0400;
  logic [7:0]  statusIn = 8'h00;
  logic [7:0]  busRdata;
  logic [15:0] busAddr, pcOut;
  logic [7:0]  busWdata, statusOut;
  logic        busWe, busy, done;

  always #4 clk = ~clk;

  irq_stack_seq u_irq_stack_seq (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .irqReq(irqReq), .brkReq(brkReq),
    .rtiReq(rtiReq), .pcIn(pcIn), .statusIn(statusIn), .busRdata(busRdata),
    .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe), .pcOut(pcOut),
    .statusOut(statusOut), .busy(busy), .done(done)
  );

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [15:0] addr;
    logic        we;
    logic [7:0]  data;
    string       tag;
  } busItem_t;
  busItem_t expQ[$];

  logic [7:0] stackMem [256];
  logic [7:0] expMem [256];
  logic [7:0] expSp;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) stackMem[i] <= 8'(i) ^ 8'h5A;
    end else if (busWe && busAddr[15:8] == 8'h01) begin
      stackMem[busAddr[7:0]] <= busWdata;
    end
  end

  always_comb begin
    case (busAddr)
      16'hFFFA: busRdata = 8'h34;
      16'hFFFB: busRdata = 8'h12;
      16'hFFFC: busRdata = 8'h00;
      16'hFFFD: busRdata = 8'hC0;
      16'hFFFE: busRdata = 8'h00;
      16'hFFFF: busRdata = 8'h20;
      default:  busRdata = (busAddr[15:8] == 8'h01) ? stackMem[busAddr[7:0]] : 8'hEA;
    endcase
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  // Scoreboard monitor: every busy cycle must match the next expected transaction
  always @(negedge clk) begin
    if (rstN) begin
      total++;
      if (busy) begin
        if (expQ.size() == 0) begin
          bad++;
          $display("FAIL R9 unexpected busy cycle got addr=%h exp idle", busAddr);
        end else begin
          busItem_t it;
          it = expQ.pop_front();
          if (busAddr !== it.addr || busWe !== it.we || (it.we && busWdata !== it.data)) begin
            bad++;
            $display("FAIL %s bus got addr=%h we=%b data=%h exp addr=%h we=%b data=%h",
                     it.tag, busAddr, busWe, busWdata, it.addr, it.we, it.data);
          end
        end
      end else if (busWe !== 1'b0 || busAddr !== pcIn) begin
        bad++;
        $display("FAIL R9 idle bus got addr=%h we=%b exp addr=%h we=0", busAddr, busWe, pcIn);
      end
    end
  end

  task automatic pushItem(input logic [15:0] a, input logic w, input logic [7:0] d, input string tag);
    busItem_t it;
    it.addr = a; it.we = w; it.data = d; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic expEntry(input cause_e c, input logic [15:0] ret, input logic [7:0] st, input string tag);
    logic [15:0] vec;
    logic [7:0] ps;
    vec = (c == K_NMI) ? 16'hFFFA : (c == K_RST) ? 16'hFFFC : 16'hFFFE;
    ps = {st[7:6], 1'b1, (c == K_BRK), st[3:0]};
    pushItem(pcIn, 1'b0, 8'h00, tag);
    pushItem(pcIn, 1'b0, 8'h00, tag);
    if (c == K_RST) begin
      for (int k = 0; k < 3; k++) pushItem({8'h01, expSp}, 1'b0, 8'h00, tag);
    end else begin
      pushItem({8'h01, expSp}, 1'b1, ret[15:8], tag); expMem[expSp] = ret[15:8]; expSp--;
      pushItem({8'h01, expSp}, 1'b1, ret[7:0], tag);  expMem[expSp] = ret[7:0];  expSp--;
      pushItem({8'h01, expSp}, 1'b1, ps, tag);        expMem[expSp] = ps;        expSp--;
    end
    pushItem(vec, 1'b0, 8'h00, tag);
    pushItem(vec + 16'd1, 1'b0, 8'h00, tag);
  endtask

  task automatic expRti(input string tag, output logic [15:0] pc, output logic [7:0] st);
    logic [7:0] b [3];
    pushItem(pcIn, 1'b0, 8'h00, tag);
    pushItem(pcIn, 1'b0, 8'h00, tag);
    pushItem({8'h01, expSp}, 1'b0, 8'h00, tag);
    for (int k = 0; k < 3; k++) begin
      expSp++;
      b[k] = expMem[expSp];
      pushItem({8'h01, expSp}, 1'b0, 8'h00, tag);
    end
    pc = {b[2], b[1]};
    st = {b[0][7:6], 2'b10, b[0][3:0]};
  endtask

  function automatic logic [7:0] entryOut(input logic [7:0] st);
    return {st[7:6], 2'b10, st[3], 1'b1, st[1:0]};
  endfunction

  task automatic waitDone(input logic [15:0] ePc, input logic [7:0] eSt, input string tag, input int left);
    @(negedge clk);
    while (!done) @(negedge clk);
    chk(pcOut === ePc, tag, "pcOut", 32'(pcOut), 32'(ePc));
    chk(statusOut === eSt, tag, "statusOut", 32'(statusOut), 32'(eSt));
    chk(expQ.size() == left, tag, "pending bus items", 32'(expQ.size()), 32'(left));
  endtask

  task automatic checkIdle(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(busy === 1'b0, tag, "busy while no cause", 32'(busy), 32'd0);
    end
  endtask

  task automatic pulse(input logic [1:0] which);
    @(posedge clk); #1;
    brkReq = which[0]; rtiReq = which[1];
    @(posedge clk); #1;
    brkReq = 1'b0; rtiReq = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired got=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] ePc;
    logic [7:0]  eSt;
    for (int i = 0; i < 256; i++) expMem[i] = 8'(i) ^ 8'h5A;
    expSp = 8'hFF;

    // R1: reset state and reset sequence
    repeat (3) @(negedge clk);
    chk(busWe === 1'b0, "R1", "busWe in reset", 32'(busWe), 32'd0);
    chk(done === 1'b0, "R1", "done in reset", 32'(done), 32'd0);
    expEntry(K_RST, 16'h0, statusIn, "R1");
    @(posedge clk); #1 rstN = 1'b1;
    waitDone(16'hC000, 8'h24, "R1", 0);

    // R6, R8: return right after reset pulls wrap from 0x01FF to 0x0100..0x0102
    pcIn = 16'h0500;
    expRti("R6", ePc, eSt);
    pulse(2'b10);
    waitDone(ePc, eSt, "R8", 0);

    // R2, R10: NMI entry, decimal bit passes through; pushes wrap to 0x01FF
    pcIn = 16'h8123; statusIn = 8'hC9;
    expEntry(K_NMI, pcIn, statusIn, "R2");
    @(posedge clk); #1 nmiReq = 1'b1;
    waitDone(16'h1234, entryOut(8'hC9), "R10", 0);
    checkIdle(4, "R2");
    nmiReq = 1'b0;

    // R3: masked IRQ ignored, then taken once unmasked
    statusIn = 8'h04; irqReq = 1'b1;
    checkIdle(6, "R3");
    pcIn = 16'h0777;
    expEntry(K_IRQ, pcIn, 8'h00, "R3");
    @(posedge clk); #1 statusIn = 8'h00;
    @(posedge clk); #1 irqReq = 1'b0;
    waitDone(16'h2000, 8'h24, "R3", 0);

    // R4: break pushes PC+2 with bit 4 set
    pcIn = 16'h3000; statusIn = 8'h01;
    expEntry(K_BRK, 16'h3002, statusIn, "R4");
    pulse(2'b01);
    waitDone(16'h2000, 8'h25, "R4", 0);

    // R8: return after break clears bit 4 in delivered status
    expRti("R8", ePc, eSt);
    pulse(2'b10);
    waitDone(ePc, eSt, "R8", 0);
    chk(ePc === 16'h3002, "R8", "model return address", 32'(ePc), 32'h3002);

    // R5: NMI before IRQ, break dropped
    pcIn = 16'h4444; statusIn = 8'h00;
    expEntry(K_NMI, pcIn, statusIn, "R5");
    expEntry(K_IRQ, pcIn, statusIn, "R5");
    @(posedge clk); #1 nmiReq = 1'b1; irqReq = 1'b1; brkReq = 1'b1;
    @(posedge clk); #1 brkReq = 1'b0;
    waitDone(16'h1234, 8'h24, "R5", 7);
    @(posedge clk); #1 irqReq = 1'b0;
    waitDone(16'h2000, 8'h24, "R5", 0);
    checkIdle(3, "R5");
    nmiReq = 1'b0;

    // R7: NMI edge during break takes over its sequence
    pcIn = 16'h5000; statusIn = 8'h00;
    expEntry(K_NMI, 16'h5002, statusIn, "R7");
    @(posedge clk); #1 brkReq = 1'b1;
    @(posedge clk); #1 brkReq = 1'b0; nmiReq = 1'b1;
    waitDone(16'h1234, 8'h24, "R7", 0);
    checkIdle(4, "R7");
    nmiReq = 1'b0;
    repeat (2) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule